// File: doc/BRIEF.md
# Four-Region Chip-Select Address Decoder

This block turns a read address in a memory-mapped flash window into a device selection. Four flash devices share the window, two on each of two channels. Each device has its own size setting in kilobytes. The devices are stacked from the bottom of the window in a fixed order. Each region starts where the one below it ends, so the region bounds come from running sums of the four sizes. There are no fixed base addresses.

A size of zero takes a device out of the map. Its chip select is then never driven, and the addresses it would have held belong to the next device up. Setting one size alone to a non-zero value lets that device cover the whole window. For each access the block returns the chip-select index, a one-hot chip-select vector, the byte offset within the selected device, and an out-of-range flag. The results are registered and appear one cycle after the request.

Top module: `cs_region_decode`

## Requirements
- R1: After reset all four sizes are zero. Every access then returns `rsp_err`=1 and `rsp_sel`=0.
- R2: The regions are stacked in the order index 0, 1, 2, 3 from address 0 upward. Region k starts at the sum of the byte sizes of regions 0 to k-1. An address inside region k returns `rsp_cs`=k.
- R3: A size value v gives a region of v*1024 bytes. The last byte of the region lies at its start plus v*1024-1.
- R4: A region whose size is zero is never selected. Addresses at its start go to the next region above it that has a non-zero size.
- R5: `rsp_offset` equals the request address minus the start of the selected region.
- R6: An address at or above the sum of all four byte sizes returns `rsp_err`=1, `rsp_sel`=0, `rsp_cs`=0 and `rsp_offset`=0.
- R7: A request sampled with `req_valid`=1 at a rising edge produces its result and `rsp_valid`=1 after that same edge. A cycle with `req_valid`=0 gives `rsp_valid`=0 after the next edge.
- R8: A size write (`cfg_we`=1, `cfg_sel` picks index 0 to 3) presented in the same cycle as a request does not affect that request. It takes effect from the next request onward.
- R9: A single non-zero size may cover the whole map. With only index 3 non-zero, address 0 selects chip select 3 at offset 0.
- R10: On a hit, `rsp_sel` is one-hot with bit `rsp_cs` set and `rsp_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for a size setting |
| cfg_sel | input | 2 | Index of the size setting to write (0..3) |
| cfg_size | input | SIZE_W | New size in kilobytes |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | ADDR_W | Byte address relative to the window base |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_err | output | 1 | Address is past the last mapped byte |
| rsp_cs | output | 2 | Selected chip-select index |
| rsp_sel | output | 4 | One-hot chip-select lines, all zero on error |
| rsp_offset | output | ADDR_W | Byte offset within the selected device |

## Verification
The bench probes the first and last byte of each region. A design that adds the sizes without scaling them to kilobytes, or that compares with the wrong kind of inequality, moves a boundary by one byte or by a factor of 1024. It also places a zero-size region in the middle of the map. A decoder that does not skip that region would select a chip select that has no device. Further tests cover the first address past the total size, a size write in the same cycle as a lookup, and a map where one upper device covers everything. Errors there would show as a missing error flag, a response that uses the new sizes one cycle too early, or an offset that is not rebased to zero.

// File: rtl/cs_region_decode.sv
module cs_region_decode #(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 16,
  parameter int KB_SHIFT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [1:0]        rsp_cs,
  output logic [3:0]        rsp_sel,
  output logic [ADDR_W-1:0] rsp_offset
);
  localparam int NCS   = 4;
  localparam int BYT_W = SIZE_W + KB_SHIFT;
  localparam int EXT_W = ((BYT_W > ADDR_W) ? BYT_W : ADDR_W) + 2;

  logic [NCS-1:0][SIZE_W-1:0] size_q;
  logic [NCS:0][EXT_W-1:0]    bound;
  logic [NCS-1:0]             below;
  logic [EXT_W-1:0]           addr_x;
  logic [1:0]                 idx;
  logic                       hit;

  assign addr_x   = EXT_W'(req_addr);
  assign bound[0] = '0;

  for (genvar g = 0; g < NCS; g++) begin : g_region
    always_ff @(posedge clk) begin
      if (!rst_n)                             size_q[g] <= '0;
      else if (cfg_we && cfg_sel == 2'(g))    size_q[g] <= cfg_size;
    end
    assign bound[g+1] = bound[g] + (EXT_W'(size_q[g]) << KB_SHIFT);
    assign below[g]   = addr_x < bound[g+1];
  end

  assign hit = |below;

  always_comb begin
    idx = 2'd0;
    for (int i = NCS - 1; i >= 0; i--)
      if (below[i]) idx = 2'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_cs     <= '0;
      rsp_sel    <= '0;
      rsp_offset <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_err    <= !hit;
        rsp_cs     <= hit ? idx : 2'd0;
        rsp_sel    <= hit ? (4'b0001 << idx) : 4'b0000;
        rsp_offset <= hit ? ADDR_W'(addr_x - bound[idx]) : '0;
      end
    end
  end
endmodule

module cs_region_decode_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [1:0]        rsp_cs,
  input logic [3:0]        rsp_sel,
  input logic [ADDR_W-1:0] rsp_offset
);
  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_idle_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_err_no_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_sel == 4'b0000));
  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_sel));
  assert_sel_matches_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> (rsp_sel == (4'b0001 << rsp_cs)));
  assert_offset_in_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid ##1 (rsp_valid && !rsp_err)) |-> (rsp_offset <= $past(req_addr)));
endmodule

bind cs_region_decode cs_region_decode_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_cs(rsp_cs),
  .rsp_sel(rsp_sel), .rsp_offset(rsp_offset)
);

// File: tb/test_cs_region_decode.sv
module test_cs_region_decode;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_sel = '0;
  logic [SIZE_W-1:0] cfg_size = '0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              rsp_valid, rsp_err;
  logic [1:0]        rsp_cs;
  logic [3:0]        rsp_sel;
  logic [ADDR_W-1:0] rsp_offset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_region_decode #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_cs_region_decode (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_size(cfg_size), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_cs(rsp_cs),
    .rsp_sel(rsp_sel), .rsp_offset(rsp_offset)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_size(input logic [1:0] sel, input logic [SIZE_W-1:0] kb);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_size = kb;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic expect_access(input string req, input logic [ADDR_W-1:0] a,
                               input bit exp_err, input logic [1:0] exp_cs,
                               input logic [ADDR_W-1:0] exp_off);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, 64'(rsp_valid), 64'd1);
    check({req, " err"}, 64'(rsp_err), 64'(exp_err));
    check({req, " cs"}, 64'(rsp_cs), exp_err ? 64'd0 : 64'(exp_cs));
    check({req, " sel"}, 64'(rsp_sel), exp_err ? 64'd0 : 64'(4'b0001 << exp_cs));
    check({req, " offset"}, 64'(rsp_offset), exp_err ? 64'd0 : 64'(exp_off));
  endtask

  task automatic t_reset;
    check("R7 reset valid", 64'(rsp_valid), 64'd0);
    expect_access("R1 empty map", 32'd0, 1'b1, 2'd0, 32'd0);
  endtask

  task automatic t_stack;
    set_size(2'd0, 16'd4);
    set_size(2'd1, 16'd0);
    set_size(2'd2, 16'd8);
    set_size(2'd3, 16'd2);
    expect_access("R2 first byte cs0", 32'd0, 1'b0, 2'd0, 32'd0);
    expect_access("R3 last byte cs0", 32'd4095, 1'b0, 2'd0, 32'd4095);
    expect_access("R4 skip zero cs1", 32'd4096, 1'b0, 2'd2, 32'd0);
    expect_access("R5 last byte cs2", 32'd12287, 1'b0, 2'd2, 32'd8191);
    expect_access("R2 first byte cs3", 32'd12288, 1'b0, 2'd3, 32'd0);
    expect_access("R10 last byte cs3", 32'd14335, 1'b0, 2'd3, 32'd2047);
    expect_access("R6 just past end", 32'd14336, 1'b1, 2'd0, 32'd0);
    expect_access("R6 top address", 32'hFFFF_FFFF, 1'b1, 2'd0, 32'd0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check("R7 idle valid", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_size = 16'd1;
    req_valid = 1'b1; req_addr = 32'd4000;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R8 old sizes cs", 64'(rsp_cs), 64'd0);
    check("R8 old sizes offset", 64'(rsp_offset), 64'd4000);
    expect_access("R8 new sizes", 32'd4000, 1'b0, 2'd2, 32'd2976);
  endtask

  task automatic t_single;
    set_size(2'd0, 16'd0);
    set_size(2'd2, 16'd0);
    set_size(2'd3, 16'd16);
    expect_access("R9 only cs3 base", 32'd0, 1'b0, 2'd3, 32'd0);
    expect_access("R9 only cs3 top", 32'd16383, 1'b0, 2'd3, 32'd16383);
    expect_access("R9 only cs3 past", 32'd16384, 1'b1, 2'd0, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stack();
    t_idle();
    t_same_cycle();
    t_single();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule